// File: doc/BRIEF.md
# Broken Ring Report Arbiter

Each node on the counter-rotating second ring carries one of these controllers. When the node's ring-1 loss-of-signal alert rises, the controller starts sending a fixed, pre-encoded report frame out on ring 2 toward the master. It repeats that frame until the master answers. An acknowledge frame orders the node to split the dual ring into two single rings. A master-reset frame orders a shutdown, in which every power switch goes to the off state.

Several nodes can detect the same break, so their reports can collide. The arbiter resolves this without any central control. When a node sees a report frame arrive from upstream, it sets a mute flag. If it is part-way through its own frame header, it finishes that header and then stops. From then on it only forwards ring-2 traffic, through a short delay line. The only report that reaches the master intact is the one from the node nearest the fault.

States: IDLE (forwarding, not reporting), SEND (own frame on the line), HDR_TAIL (muted, finishing the header), MUTED (forwarding only, mute flag set), RESOLVED (master has answered, waiting for the alert to drop). Transitions:
- any state to RESOLVED on a master reset.
- SEND, HDR_TAIL or MUTED to RESOLVED on an acknowledge.
- IDLE to SEND on the alert.
- IDLE to MUTED on an incoming report.
- SEND to HDR_TAIL on an incoming report inside the header.
- SEND to MUTED on an incoming report after the header.
- HDR_TAIL to MUTED at the last header bit.
- RESOLVED to IDLE when the alert drops.

Top module: `ring_report_arbiter`

## Requirements
- R1: After reset, tx_bit_o is 0 and reconfig_o and shutdown_o are 0.
- R2: In IDLE, with the alert high and no incoming report, the node starts sending on the next cycle. The cycle after the edge shows FRAME_PAT bit 49, and the following bits are sent MSB first, one per cycle.
- R3: While in SEND, the 50-bit frame repeats without a gap. Bit k of each repetition is FRAME_PAT[49-k].
- R4: Whenever the node is not sending its own bits, tx_bit_o equals rx_bit_i as sampled 8 clock edges earlier.
- R5: An incoming report strobe while the node is sending bit c of its frame, with c < 9, lets the node send header bits c+1 through 9 (the header is bits 0..9). After that it forwards.
- R6: An incoming report strobe while the node is sending bit c, with c ≥ 9, makes the node forward from the next cycle.
- R7: An incoming report strobe in IDLE sets the mute flag. A later alert then has no effect: the node keeps forwarding until the master answers.
- R8: An acknowledge strobe in SEND, HDR_TAIL or MUTED gives a one-cycle reconfig_o pulse on the next cycle, clears the mute flag and ends reporting.
- R9: A master-reset strobe in any state gives a one-cycle shutdown_o pulse on the next cycle and ends reporting. If an acknowledge arrives in the same cycle, the master reset wins and reconfig_o stays 0.
- R10: After the master answers, the node does not report again while the alert stays high. It returns to IDLE once the alert is low. An acknowledge in IDLE or RESOLVED produces no reconfig_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alert_i | input | 1 | Local ring-1 broken alert (level) |
| rx_bit_i | input | 1 | Serial data arriving on ring 2 |
| rpt_det_i | input | 1 | One-cycle strobe: incoming report frame recognised |
| ack_det_i | input | 1 | One-cycle strobe: acknowledge frame from master |
| mr_det_i | input | 1 | One-cycle strobe: master-reset frame |
| tx_bit_o | output | 1 | Serial data leaving on ring 2 |
| reconfig_o | output | 1 | One-cycle command to split into single rings |
| shutdown_o | output | 1 | One-cycle command to turn all switches off |

## Verification
The assertions assume the three detect inputs are single-cycle strobes. They also assume an acknowledge and a master reset may coincide, in which case the master reset takes priority. The stimulus builds every strobe as a one-cycle pulse. Random traffic makes these pulses rare relative to the frame length, so frames, header interruptions and mute periods all occur. Directed cases place the report strobe inside the header, after it, and in IDLE, and they drive acknowledge together with master reset.

// File: rtl/ring_rpt_pkg.sv
package ring_rpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HDR_TAIL,
        ST_MUTED,
        ST_RESOLVED
    } rpt_state_t;
endpackage

// File: rtl/fwd_delay.sv
module fwd_delay #(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] stage_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[i] <= 1'b0;
                    else        stage_q[i] <= stage_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int                    FRAME_BITS = 50,
    parameter logic [FRAME_BITS-1:0] FRAME_PAT  = 50'h2A5C3F0E19B47,
    localparam int                   CW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    output logic          bit_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] sh_q;
    logic [CW-1:0]         cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= FRAME_PAT;
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= FRAME_PAT;
            cnt_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[FRAME_BITS-2:0], sh_q[FRAME_BITS-1]};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign bit_o = sh_q[FRAME_BITS-1];
    assign cnt_o = cnt_q;

    // R3: the bit index wraps after the last frame bit
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && cnt_q == LAST) |=> cnt_q == '0);
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/report_fsm.sv
module report_fsm
    import ring_rpt_pkg::*;
#(
    parameter int  FRAME_BITS = 50,
    parameter int  HDR_BITS   = 10,
    localparam int CW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alert_i,
    input  logic          rpt_det_i,
    input  logic          ack_det_i,
    input  logic          mr_det_i,
    input  logic [CW-1:0] cnt_i,
    output rpt_state_t    state_o,
    output logic          load_o,
    output logic          shift_o,
    output logic          reconfig_o,
    output logic          shutdown_o
);
    localparam logic [CW-1:0] HDR_LAST = CW'(HDR_BITS - 1);

    rpt_state_t state_q, state_d;
    logic       rec_d, shut_d;
    logic       rec_q, shut_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rec_q   <= 1'b0;
            shut_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
            shut_q  <= shut_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rec_d   = 1'b0;
        shut_d  = 1'b0;
        if (mr_det_i) begin
            state_d = ST_RESOLVED;
            shut_d  = 1'b1;
        end else if (ack_det_i && (state_q == ST_SEND || state_q == ST_HDR_TAIL
                                   || state_q == ST_MUTED)) begin
            state_d = ST_RESOLVED;
            rec_d   = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rpt_det_i)    state_d = ST_MUTED;
                    else if (alert_i) state_d = ST_SEND;
                end
                ST_SEND: begin
                    if (rpt_det_i)
                        state_d = (cnt_i < HDR_LAST) ? ST_HDR_TAIL : ST_MUTED;
                end
                ST_HDR_TAIL: begin
                    if (cnt_i == HDR_LAST) state_d = ST_MUTED;
                end
                ST_MUTED: state_d = ST_MUTED;
                ST_RESOLVED: begin
                    if (!alert_i) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        load_o     = (state_q == ST_IDLE) && (state_d == ST_SEND);
        shift_o    = (state_q == ST_SEND) || (state_q == ST_HDR_TAIL);
        reconfig_o = rec_q;
        shutdown_o = shut_q;
        state_o    = state_q;
    end

    // R9: master reset always leads to a shutdown pulse
    p_mr_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mr_det_i |=> (shutdown_o && !reconfig_o));
    // R8: acknowledge while involved leads to a reconfigure pulse
    p_ack_reconfig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_det_i && !mr_det_i && (state_q == ST_MUTED || state_q == ST_SEND
                                    || state_q == ST_HDR_TAIL)) |=> reconfig_o);
    // R7: the mute flag holds until the master answers
    p_muted_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && !ack_det_i && !mr_det_i) |=> state_q == ST_MUTED);
    // R5: header completion never runs past the header
    p_tail_in_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HDR_TAIL |-> cnt_i <= HDR_LAST);
    // R2: alert in idle starts a report
    p_alert_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && alert_i && !rpt_det_i && !mr_det_i)
        |=> (state_q == ST_SEND && cnt_i == '0));
    // R10: no pulses outside an answer, and never both
    p_cmd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reconfig_o && shutdown_o));
    p_no_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVED && alert_i) |=> state_q != ST_SEND);
endmodule

// File: rtl/ring_report_arbiter.sv
module ring_report_arbiter
    import ring_rpt_pkg::*;
#(
    parameter int                    FRAME_BITS = 50,
    parameter int                    HDR_BITS   = 10,
    parameter int                    FWD_DEPTH  = 8,
    parameter logic [FRAME_BITS-1:0] FRAME_PAT  = 50'h2A5C3F0E19B47
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_i,
    input  logic rx_bit_i,
    input  logic rpt_det_i,
    input  logic ack_det_i,
    input  logic mr_det_i,
    output logic tx_bit_o,
    output logic reconfig_o,
    output logic shutdown_o
);
    localparam int CW = $clog2(FRAME_BITS);

    rpt_state_t    state;
    logic          load, shift, frame_bit, fwd_bit, own_active;
    logic [CW-1:0] cnt;

    fwd_delay #(.DEPTH(FWD_DEPTH)) u_delay (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_bit_i),
        .dout (fwd_bit)
    );

    frame_shifter #(.FRAME_BITS(FRAME_BITS), .FRAME_PAT(FRAME_PAT)) u_frame (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(shift),
        .bit_o(frame_bit),
        .cnt_o(cnt)
    );

    report_fsm #(.FRAME_BITS(FRAME_BITS), .HDR_BITS(HDR_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .alert_i   (alert_i),
        .rpt_det_i (rpt_det_i),
        .ack_det_i (ack_det_i),
        .mr_det_i  (mr_det_i),
        .cnt_i     (cnt),
        .state_o   (state),
        .load_o    (load),
        .shift_o   (shift),
        .reconfig_o(reconfig_o),
        .shutdown_o(shutdown_o)
    );

    assign own_active = (state == ST_SEND) || (state == ST_HDR_TAIL);
    assign tx_bit_o   = own_active ? frame_bit : fwd_bit;
endmodule

// File: tb/test_ring_report_arbiter.sv
module test_ring_report_arbiter;
    localparam logic [49:0] PAT = 50'h2A5C3F0E19B47;
    localparam int S_IDLE = 0, S_SEND = 1, S_TAIL = 2, S_MUTE = 3, S_RES = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alert = 0, rxb = 0, det = 0, ack = 0, mr = 0;
    logic tx, rec, shut;
    int errors = 0, checks = 0;
    string tag = "R1";
    bit done = 0;

    int m_st = S_IDLE, m_cnt = 0;
    logic [7:0] hist = '0;
    logic e_rec = 0, e_shut = 0;

    always #4 clk = ~clk;

    ring_report_arbiter i_ring_report_arbiter (
        .clk(clk), .rst_n(rst_n), .alert_i(alert), .rx_bit_i(rxb),
        .rpt_det_i(det), .ack_det_i(ack), .mr_det_i(mr),
        .tx_bit_o(tx), .reconfig_o(rec), .shutdown_o(shut));

    function automatic logic exp_tx();
        if (m_st == S_SEND || m_st == S_TAIL) return PAT[49 - m_cnt];
        return hist[7];
    endfunction

    task automatic model_edge();
        int nx = m_st;
        logic own = (m_st == S_SEND || m_st == S_TAIL);
        e_rec = 0; e_shut = 0;
        if (mr) begin nx = S_RES; e_shut = 1; end
        else if (ack && (m_st == S_SEND || m_st == S_TAIL || m_st == S_MUTE)) begin
            nx = S_RES; e_rec = 1;
        end else begin
            case (m_st)
                S_IDLE: if (det) nx = S_MUTE; else if (alert) nx = S_SEND;
                S_SEND: if (det) nx = (m_cnt < 9) ? S_TAIL : S_MUTE;
                S_TAIL: if (m_cnt == 9) nx = S_MUTE;
                S_RES:  if (!alert) nx = S_IDLE;
                default: ;
            endcase
        end
        if (m_st == S_IDLE && nx == S_SEND) m_cnt = 0;
        else if (own) m_cnt = (m_cnt + 1) % 50;
        hist = {hist[6:0], rxb};
        m_st = nx;
    endtask

    task automatic check(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic cyc(logic a, logic r, logic d, logic k, logic m);
        alert = a; rxb = r; det = d; ack = k; mr = m;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        det = 0; ack = 0; mr = 0;
        check("tx_bit_o", tx, exp_tx());
        check("reconfig_o", rec, e_rec);
        check("shutdown_o", shut, e_shut);
    endtask

    task automatic run(int n, logic a);
        for (int i = 0; i < n; i++) cyc(a, 1'($urandom), 0, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        tag = "R1";
        check("tx_bit_o", tx, 1'b0); check("reconfig_o", rec, 1'b0);
        check("shutdown_o", shut, 1'b0);
        tag = "R4"; run(25, 0);
        tag = "R2"; run(50, 1);
        tag = "R3"; run(70, 1);
        // R5: report strobe inside the header
        tag = "R8"; cyc(1, 0, 0, 1, 0); tag = "R10"; run(10, 1); run(3, 0);
        tag = "R5"; run(4, 1); cyc(1, 1, 1, 0, 0); run(20, 1);
        tag = "R8"; cyc(1, 0, 0, 1, 0);
        tag = "R10"; run(6, 1); run(2, 0); cyc(0, 0, 0, 1, 0); run(3, 0);
        // R6: report strobe after the header
        tag = "R6"; run(30, 1); cyc(1, 1, 1, 0, 0); run(20, 1);
        tag = "R9"; cyc(1, 0, 0, 0, 1); run(4, 0);
        // R7: report strobe in idle, then alert
        tag = "R7"; cyc(0, 1, 1, 0, 0); run(60, 1);
        tag = "R9"; cyc(1, 0, 0, 1, 1); run(4, 0);
        // R5 boundary: strobe on the last header bit
        tag = "R5"; run(10, 1); cyc(1, 0, 1, 0, 0); run(12, 1);
        tag = "R9"; cyc(0, 0, 0, 0, 1); run(3, 0);
        // random mix
        tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            logic a = ($urandom % 64 == 0) ? ~alert : alert;
            cyc(a, 1'($urandom), ($urandom % 45) == 0,
                ($urandom % 90) == 0, ($urandom % 170) == 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule